// File: doc/BRIEF.md
# Configurable Registered ROM Read Path

This block is a synchronous model of a byte-wide read-only memory whose read path has a configurable front end and back end. A read address arrives on a parallel bus and either reaches the array directly or passes an address latch controlled by a latch-enable pin. The latch-enable polarity can be selected. The addressed word is always captured into an output register on the rising clock edge, and the outputs show only that register. A separate output-enable pin decides whether the outputs drive. It acts either combinationally or as a flag sampled on the clock. Outputs that would be high-impedance are modelled as a data bus plus a valid flag.

Contents and configuration are loaded through a byte-write programming port. The programming address is one bit wider than the read address. When that extra top bit is clear, a write stores a data word. When it is set, the write stores the architecture byte. Only the three low bits of that byte are used. The architecture byte is not cleared by reset, so it behaves like a non-volatile setting. It reads as zero until it is written. The address width is a parameter: the full device uses 15 bits, and the default is reduced to 11 bits to keep the model small.

The address latch is a two-state machine. LAT_FOLLOW is entered at any clock edge where the latch enable is active; in that state the held address register copies the input address. LAT_HOLD is entered at any edge where the latch enable is inactive; in that state the held address is frozen. Reset forces LAT_FOLLOW with a held address of zero.

Top module: `rom_registered_top`

## Requirements
- R1: On every rising clock edge that is not a reset edge, the output register loads the array word at the current effective address. The `dout` port always shows the register, never the raw array data.
- R2: With architecture bit 1 clear (the default), the latch-enable pin has no effect, and the effective address equals `addr_in`.
- R3: With architecture bit 1 set, the effective address follows `addr_in` while the latch enable is active. When the enable is inactive, the effective address is the value held from the last clock edge at which the enable was active. Address changes made while the latch is closed do not reach `dout`.
- R4: Architecture bit 2 sets the latch-enable polarity: 0 makes `ale` active high, and 1 makes it active low.
- R5: With architecture bit 0 clear (the default), `dout_valid` equals the inverse of `oe_n` combinationally, with no clock needed.
- R6: With architecture bit 0 set, `dout_valid` equals the inverse of `oe_n` as sampled at the last rising edge. It does not change between edges.
- R7: A synchronous active-high reset clears the output register to 0, clears the sampled enable to the disabled state and clears the held address to 0. It leaves the architecture byte unchanged.
- R8: A programming write with `pgm_addr[ADDR_W]` set loads `pgm_data[2:0]` into the architecture byte, which takes effect from the next clock edge. A write with that bit clear stores `pgm_data` at word `pgm_addr[ADDR_W-1:0]`. The architecture byte starts at 0.
- R9: A data write and a read of the same word at the same edge return the old content. The new content is seen from the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge loads the output register |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | ADDR_W | Read address |
| ale | input | 1 | Address latch enable, polarity per architecture bit 2 |
| oe_n | input | 1 | Output enable, active low |
| pgm_we | input | 1 | Programming write strobe |
| pgm_addr | input | ADDR_W+1 | Programming address; top bit selects the architecture byte |
| pgm_data | input | DATA_W | Programming data |
| dout | output | DATA_W | Output register contents |
| dout_valid | output | 1 | Outputs driving (1) or high-impedance (0) |

## Verification
All eight architecture settings are driven with random addresses, random latch-enable levels and random enable levels. This mix separates the transparent path from the latched path and active-high from active-low latching. Directed sequences then change the address while the latch is closed, which shows whether the held value or the live address is read. They also toggle `oe_n` between clock edges, which separates combinational enabling from sampled enabling. Same-edge write/read and a reset with the synchronous mode selected check the old-data rule and the fact that reset does not clear the configuration.

// File: rtl/rom_cfg_pkg.sv
package rom_cfg_pkg;

    // Architecture byte, low three bits: [2] latch polarity, [1] latch use, [0] sync enable
    typedef struct packed {
        logic ale_low;
        logic ale_used;
        logic oe_sync;
    } rom_arch_t;

    typedef enum logic {
        LAT_FOLLOW = 1'b0,
        LAT_HOLD   = 1'b1
    } lat_state_t;

endpackage

// File: rtl/rom_addr_latch.sv
module rom_addr_latch
    import rom_cfg_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              use_latch,
    input  logic              pol_low,
    input  logic              ale,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] eff_addr
);

    lat_state_t        state_q, state_d;
    logic [ADDR_W-1:0] held_q;
    logic              active;

    assign active = pol_low ? ~ale : ale;

    always_comb begin
        unique case (active)
            1'b1:    state_d = LAT_FOLLOW;
            default: state_d = LAT_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LAT_FOLLOW;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == LAT_FOLLOW) begin
                held_q <= addr_in;
            end
        end
    end

    always_comb begin
        if (!use_latch || active) begin
            eff_addr = addr_in;
        end else begin
            eff_addr = held_q;
        end
    end

    // R3: a closed latch keeps its held address
    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == LAT_HOLD && !active) |=> $stable(held_q));

    // R3: an open latch captures the live address
    assert_follow_capture_R3: assert property (@(posedge clk) disable iff (rst)
        active |=> (held_q == $past(addr_in) && state_q == LAT_FOLLOW));

endmodule

// File: rtl/rom_array.sv
module rom_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/rom_out_enable.sv
module rom_out_enable (
    input  logic clk,
    input  logic rst,
    input  logic sync_mode,
    input  logic oe_n,
    output logic out_valid
);

    logic en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
        end else begin
            en_q <= ~oe_n;
        end
    end

    always_comb begin
        unique case (sync_mode)
            1'b1:    out_valid = en_q;
            default: out_valid = ~oe_n;
        endcase
    end

    // R6: in sampled mode the flag reflects the enable seen at the last edge
    assert_sync_sample_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (!sync_mode || out_valid == !$past(oe_n)));

    // R7: reset leaves the sampled enable disabled
    assert_reset_disable_R7: assert property (@(posedge clk)
        rst |=> !en_q);

endmodule

// File: rtl/rom_registered_top.sv
module rom_registered_top
    import rom_cfg_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ale,
    input  logic              oe_n,
    input  logic              pgm_we,
    input  logic [ADDR_W:0]   pgm_addr,
    input  logic [DATA_W-1:0] pgm_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid
);

    localparam int ARCH_W = $bits(rom_arch_t);

    rom_arch_t         arch_q = '0;
    logic              cfg_sel;
    logic              data_we;
    logic [ADDR_W-1:0] eff_addr;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] out_q;

    assign cfg_sel = pgm_addr[ADDR_W];
    assign data_we = pgm_we && !cfg_sel;

    always_ff @(posedge clk) begin
        if (pgm_we && cfg_sel) begin
            arch_q <= rom_arch_t'(pgm_data[ARCH_W-1:0]);
        end
    end

    rom_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .use_latch (arch_q.ale_used),
        .pol_low   (arch_q.ale_low),
        .ale       (ale),
        .addr_in   (addr_in),
        .eff_addr  (eff_addr)
    );

    rom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .we    (data_we),
        .waddr (pgm_addr[ADDR_W-1:0]),
        .wdata (pgm_data),
        .raddr (eff_addr),
        .rdata (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= rd_data;
        end
    end

    rom_out_enable u_oe (
        .clk       (clk),
        .rst       (rst),
        .sync_mode (arch_q.oe_sync),
        .oe_n      (oe_n),
        .out_valid (dout_valid)
    );

    assign dout = out_q;

    // R1: register takes the array word seen at the edge
    assert_out_load_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> dout == $past(rd_data));

    // R7: reset clears the output register
    assert_reset_clear_R7: assert property (@(posedge clk)
        rst |=> dout == '0);

    // R8: a config write lands in the architecture byte
    assert_cfg_write_R8: assert property (@(posedge clk) disable iff (rst)
        (pgm_we && cfg_sel) |=> arch_q == $past(pgm_data[ARCH_W-1:0]));

endmodule

// File: tb/tb_rom_registered_top.sv
`timescale 1ns/1ps
module tb_rom_registered_top;

    localparam int AW    = 11;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr_in;
    logic          ale;
    logic          oe_n;
    logic          pgm_we;
    logic [AW:0]   pgm_addr;
    logic [DW-1:0] pgm_data;
    logic [DW-1:0] dout;
    logic          dout_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // bench model
    logic [DW-1:0] mdl_mem [DEPTH];
    logic [2:0]    cfg_m  = 3'b000;
    logic [AW-1:0] held_m = '0;
    logic [DW-1:0] exp_q  = '0;
    logic          en_m   = 1'b0;

    always #5 clk = ~clk;

    rom_registered_top #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .addr_in(addr_in), .ale(ale), .oe_n(oe_n),
        .pgm_we(pgm_we), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
        .dout(dout), .dout_valid(dout_valid)
    );

    function automatic logic [DW-1:0] fill_val(int i);
        return DW'((i * 37 + (i >> 3)) ^ 8'h5A);
    endfunction

    function automatic logic exp_valid();
        return cfg_m[0] ? en_m : !oe_n;
    endfunction

    always @(posedge clk) begin
        logic act;
        logic [AW-1:0] ea;
        if (rst) begin
            exp_q  = '0;
            en_m   = 1'b0;
            held_m = '0;
        end else begin
            act  = cfg_m[2] ? !ale : ale;
            ea   = (!cfg_m[1] || act) ? addr_in : held_m;
            exp_q = mdl_mem[ea];
            en_m = !oe_n;
            if (act) held_m = addr_in;
        end
        if (pgm_we) begin
            if (pgm_addr[AW]) cfg_m = pgm_data[2:0];
            else mdl_mem[pgm_addr[AW-1:0]] = pgm_data;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check("R1", 32'(dout), 32'(exp_q));
        check(cfg_m[0] ? "R6" : "R5", 32'(dout_valid), 32'(exp_valid()));
    endtask

    task automatic set_cfg(logic [2:0] c);
        pgm_we   = 1'b1;
        pgm_addr = {1'b1, {AW{1'b0}}};
        pgm_data = {5'b10100, c};
        tick();
        pgm_we = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hang expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] a0, a1;
        void'($urandom(32'd1234));
        rst = 1'b1; addr_in = '0; ale = 1'b0; oe_n = 1'b1;
        pgm_we = 1'b0; pgm_addr = '0; pgm_data = '0;

        // R8: load contents through the programming port
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            pgm_we = 1'b1; pgm_addr = {1'b0, AW'(i)}; pgm_data = fill_val(i);
        end
        @(negedge clk);
        pgm_we = 1'b0;

        // R7: reset state, default config async, oe_n high
        tick();
        check("R7", 32'(dout), 32'h0);
        check("R5", 32'(dout_valid), 32'h0);
        rst = 1'b0;
        oe_n = 1'b0;
        addr_in = AW'(5);
        tick();
        check("R1", 32'(dout), 32'(fill_val(5)));

        // R8: config takes effect on the next clock
        set_cfg(3'b001);
        oe_n = 1'b1;
        tick();
        check("R6", 32'(dout_valid), 32'h0);
        // R7: reset keeps sync mode selected
        oe_n = 1'b0;
        tick();
        check("R6", 32'(dout_valid), 32'h1);
        rst = 1'b1;
        tick();
        check("R7", 32'(dout), 32'h0);
        check("R7", 32'(dout_valid), 32'h0);
        rst = 1'b0;
        tick();
        check("R7", 32'(dout_valid), 32'h1);

        // R6: mid-cycle enable change does not show until the edge
        oe_n = 1'b1;
        #1;
        check("R6", 32'(dout_valid), 32'h1);
        tick();
        check("R6", 32'(dout_valid), 32'h0);

        // R5: async enable follows combinationally
        set_cfg(3'b000);
        oe_n = 1'b0;
        #1;
        check("R5", 32'(dout_valid), 32'h1);
        oe_n = 1'b1;
        #1;
        check("R5", 32'(dout_valid), 32'h0);

        // R2: transparent mode ignores ale
        for (int k = 0; k < 4; k++) begin
            ale = k[0];
            addr_in = AW'(100 + k);
            tick();
            check("R2", 32'(dout), 32'(fill_val(100 + k)));
        end

        // R3: latched, active-high; changes while closed are ignored
        set_cfg(3'b010);
        a0 = AW'(321); a1 = AW'(777);
        ale = 1'b1; addr_in = a0;
        tick();
        check("R3", 32'(dout), 32'(fill_val(321)));
        ale = 1'b0; addr_in = a1;
        tick();
        check("R3", 32'(dout), 32'(fill_val(321)));
        addr_in = AW'(12);
        tick();
        check("R3", 32'(dout), 32'(fill_val(321)));
        ale = 1'b1;
        tick();
        check("R3", 32'(dout), 32'(fill_val(12)));

        // R4: active-low latch enable
        set_cfg(3'b110);
        ale = 1'b0; addr_in = AW'(40);
        tick();
        check("R4", 32'(dout), 32'(fill_val(40)));
        ale = 1'b1; addr_in = AW'(41);
        tick();
        check("R4", 32'(dout), 32'(fill_val(40)));

        // R9: same-edge write and read returns old data
        set_cfg(3'b000);
        addr_in = AW'(9);
        pgm_we = 1'b1; pgm_addr = {1'b0, AW'(9)}; pgm_data = 8'hC3;
        tick();
        pgm_we = 1'b0;
        check("R9", 32'(dout), 32'(fill_val(9)));
        tick();
        check("R9", 32'(dout), 32'hC3);

        // random sweep over all eight architecture settings
        for (int c = 0; c < 8; c++) begin
            set_cfg(3'(c));
            for (int n = 0; n < 250; n++) begin
                addr_in = AW'($urandom);
                ale     = 1'($urandom);
                oe_n    = 1'($urandom);
                if ($urandom_range(0, 15) == 0) begin
                    pgm_we = 1'b1;
                    pgm_addr = {1'b0, AW'($urandom)};
                    pgm_data = DW'($urandom);
                end else begin
                    pgm_we = 1'b0;
                end
                tick();
            end
            pgm_we = 1'b0;
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule